// File: doc/BRIEF.md
# Self-Routing Output-Queued Central Switch

This module is the middle stage of a three-stage cell fabric. It has one input and one output per neighbouring output module. Every arriving cell carries the index of the output module it must reach. That index alone picks the output of this module the cell leaves on. There is no arbiter and no scheduler: the destination field steers the cell straight into a FIFO that belongs to that output.

All inputs may aim at the same output in one slot, so every output FIFO accepts up to one write from each input per clock. Each FIFO drains at most one cell per clock onto its link. The link has no back-pressure, so a non-empty FIFO always presents its oldest cell and advances on the next edge.

The FIFOs are shallow and their depth is a parameter. When a FIFO runs out of room, the cells that do not fit are discarded. Each discarded cell adds one to a per-output drop counter. A per-output occupancy count is also brought out.

Top module: `oq_central_switch`

## Requirements
- R1: A cell presented with its input valid high and destination index d (field d of `in_dst`, `DST_W` bits per input, input i in bits i*DST_W upward) is stored only in the FIFO of output d. A cell with its valid low changes no FIFO and no counter.
- R2: In one clock cycle a FIFO stores one cell from each input that targets it, up to `NPORT` cells, as long as there is room for them.
- R3: Output j has its valid high exactly when FIFO j is non-empty. While it is high, output j carries the oldest cell of that FIFO. The FIFO removes one cell per clock while it is non-empty. A cell written into an empty FIFO appears on the output in the cycle after it was presented. Cells written in the same cycle leave in ascending input order.
- R4: When more cells target a FIFO in one cycle than it has room for, the cells from the lowest-numbered inputs are kept and the rest are discarded.
- R5: The drop counter of output j grows by exactly the number of cells discarded at FIFO j in each cycle, and stays unchanged when none are discarded. It wraps at 2^`CNT_W`.
- R6: A removal in a cycle frees its slot for the writes of that same cycle. A full FIFO that is draining therefore accepts one new cell per cycle.
- R7: `out_occ` field j equals the number of cells held in FIFO j and never exceeds `DEPTH`.
- R8: After a synchronous active-high reset every FIFO is empty, every output valid is low and every drop counter is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cell slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | NPORT | Per-input cell valid |
| in_cell | input | NPORT*CELL_W | Per-input cell payload, input i at bits i*CELL_W upward |
| in_dst | input | NPORT*DST_W | Per-input destination output index |
| out_vld | output | NPORT | Per-output valid; high when the FIFO holds a cell |
| out_cell | output | NPORT*CELL_W | Per-output oldest cell |
| out_occ | output | NPORT*OCC_W | Per-output FIFO occupancy |
| out_drops | output | NPORT*CNT_W | Per-output count of discarded cells |

## Verification
The bench first sends a permutation, with each input aimed at a different output. This separates correct self-routing from crossed or shared queues. It then sends all inputs to one empty output in one slot, which shows whether multi-write speedup and ascending-input FIFO order hold. Bursts into a FIFO that is already full or nearly full show which cells are kept, how many drops are counted, and whether a same-slot removal frees room. Idle slots with destinations set but valids low must change nothing. A long pseudo-random stream at heavy load is compared against a reference queue model on every cycle.

// File: rtl/oqs_pkg.sv
package oqs_pkg;

    localparam int DEF_NPORT  = 4;
    localparam int DEF_CELL_W = 16;
    localparam int DEF_DEPTH  = 4;
    localparam int DEF_CNT_W  = 16;

    // circular index advance for a ring of arbitrary depth
    function automatic int unsigned ring_step(input int unsigned base,
                                              input int unsigned off,
                                              input int unsigned depth);
        return (base + off) % depth;
    endfunction

    // width able to hold values 0..n
    function automatic int unsigned span_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/oqs_admit.sv
module oqs_admit #(
    parameter int NPORT  = 4,
    parameter int OCC_W  = 3,
    parameter int DROP_W = 3
) (
    input  logic [NPORT-1:0]            req,
    input  logic [OCC_W-1:0]            room,
    output logic [NPORT-1:0]            take,
    output logic [NPORT-1:0][OCC_W-1:0] slot,
    output logic [OCC_W-1:0]            n_take,
    output logic [DROP_W-1:0]           n_lost
);
    // ascending input order: lower inputs claim free slots first
    always_comb begin
        logic [OCC_W-1:0]  used;
        logic [DROP_W-1:0] lost;
        used = '0;
        lost = '0;
        take = '0;
        slot = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (req[i]) begin
                if (used < room) begin
                    take[i] = 1'b1;
                    slot[i] = used;
                    used    = used + 1'b1;
                end else begin
                    lost = lost + 1'b1;
                end
            end
        end
        n_take = used;
        n_lost = lost;
    end
endmodule

// File: rtl/oqs_queue.sv
module oqs_queue
    import oqs_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int CELL_W = 16,
    parameter int DEPTH  = 4,
    parameter int CNT_W  = 16,
    parameter int OCC_W  = 3,
    parameter int PTR_W  = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NPORT-1:0]             req,
    input  logic [NPORT-1:0][CELL_W-1:0] cells,
    output logic                         q_vld,
    output logic [CELL_W-1:0]            q_cell,
    output logic [OCC_W-1:0]             q_occ,
    output logic [CNT_W-1:0]             q_drops
);
    localparam int DROP_W = span_w(NPORT);

    logic [CELL_W-1:0]            mem [DEPTH];
    logic [PTR_W-1:0]             wr_ptr, rd_ptr;
    logic [OCC_W-1:0]             occ;
    logic                         pop;
    logic [OCC_W-1:0]             room;
    logic [NPORT-1:0]             take;
    logic [NPORT-1:0][OCC_W-1:0]  slot;
    logic [OCC_W-1:0]             n_take;
    logic [DROP_W-1:0]            n_lost;

    // the link always takes the head cell, so a non-empty FIFO drains
    assign pop  = (occ != '0);
    // the slot freed by this cycle's removal is usable now
    assign room = OCC_W'(DEPTH) - occ + OCC_W'(pop);

    oqs_admit #(
        .NPORT (NPORT),
        .OCC_W (OCC_W),
        .DROP_W(DROP_W)
    ) u_admit (
        .req   (req),
        .room  (room),
        .take  (take),
        .slot  (slot),
        .n_take(n_take),
        .n_lost(n_lost)
    );

    always_ff @(posedge clk) begin
        for (int i = 0; i < NPORT; i++) begin
            if (take[i]) begin
                mem[PTR_W'(ring_step(32'(wr_ptr), 32'(slot[i]), DEPTH))] <= cells[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            occ     <= '0;
            q_drops <= '0;
        end else begin
            wr_ptr  <= PTR_W'(ring_step(32'(wr_ptr), 32'(n_take), DEPTH));
            if (pop) begin
                rd_ptr <= PTR_W'(ring_step(32'(rd_ptr), 1, DEPTH));
            end
            occ     <= occ - OCC_W'(pop) + n_take;
            q_drops <= q_drops + CNT_W'(n_lost);
        end
    end

    assign q_vld  = pop;
    assign q_cell = mem[rd_ptr];
    assign q_occ  = occ;

    // admission must be a prefix of the requesters in ascending order
    logic order_bad;
    always_comb begin
        logic seen_rej;
        seen_rej  = 1'b0;
        order_bad = 1'b0;
        for (int i = 0; i < NPORT; i++) begin
            if (take[i] && (!req[i] || seen_rej)) order_bad = 1'b1;
            if (req[i] && !take[i]) seen_rej = 1'b1;
        end
    end

    p_occ_bound_r7: assert property (@(posedge clk) disable iff (rst)
        occ <= OCC_W'(DEPTH));

    p_lower_first_r4: assert property (@(posedge clk) disable iff (rst)
        !order_bad);

    p_drop_when_full_r4: assert property (@(posedge clk) disable iff (rst)
        (n_take != room) |-> (n_lost == '0));

    p_drop_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (n_lost == '0) |=> $stable(q_drops));

    p_drain_r3: assert property (@(posedge clk) disable iff (rst)
        (occ != '0 && n_take == '0) |=> (occ == $past(occ) - 1'b1));

    p_full_accepts_r6: assert property (@(posedge clk) disable iff (rst)
        (occ == OCC_W'(DEPTH) && req != '0) |-> (n_take != '0));

    p_reset_empty_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (occ == '0 && !q_vld && q_drops == '0));

endmodule

// File: rtl/oq_central_switch.sv
module oq_central_switch
    import oqs_pkg::*;
#(
    parameter int NPORT  = DEF_NPORT,
    parameter int CELL_W = DEF_CELL_W,
    parameter int DEPTH  = DEF_DEPTH,
    parameter int CNT_W  = DEF_CNT_W,
    parameter int DST_W  = (NPORT > 1) ? $clog2(NPORT) : 1,
    parameter int OCC_W  = span_w(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NPORT-1:0]         in_vld,
    input  logic [NPORT*CELL_W-1:0]  in_cell,
    input  logic [NPORT*DST_W-1:0]   in_dst,
    output logic [NPORT-1:0]         out_vld,
    output logic [NPORT*CELL_W-1:0]  out_cell,
    output logic [NPORT*OCC_W-1:0]   out_occ,
    output logic [NPORT*CNT_W-1:0]   out_drops
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [NPORT-1:0][CELL_W-1:0] cells;
    logic [NPORT-1:0][NPORT-1:0]  req;

    generate
        for (genvar i = 0; i < NPORT; i++) begin : g_in
            assign cells[i] = in_cell[i*CELL_W +: CELL_W];
        end

        for (genvar j = 0; j < NPORT; j++) begin : g_out
            // self-routing: destination field alone selects the queue
            for (genvar i = 0; i < NPORT; i++) begin : g_req
                assign req[j][i] = in_vld[i] && (in_dst[i*DST_W +: DST_W] == DST_W'(j));
            end

            oqs_queue #(
                .NPORT (NPORT),
                .CELL_W(CELL_W),
                .DEPTH (DEPTH),
                .CNT_W (CNT_W),
                .OCC_W (OCC_W),
                .PTR_W (PTR_W)
            ) u_q (
                .clk    (clk),
                .rst    (rst),
                .req    (req[j]),
                .cells  (cells),
                .q_vld  (out_vld[j]),
                .q_cell (out_cell[j*CELL_W +: CELL_W]),
                .q_occ  (out_occ[j*OCC_W +: OCC_W]),
                .q_drops(out_drops[j*CNT_W +: CNT_W])
            );
        end
    endgenerate

    // a cell on one input lands in at most one queue
    for (genvar i = 0; i < NPORT; i++) begin : g_chk
        logic [NPORT-1:0] hit;
        for (genvar j = 0; j < NPORT; j++) begin : g_col
            assign hit[j] = req[j][i];
        end
        p_one_queue_r1: assert property (@(posedge clk) disable iff (rst)
            $onehot0(hit));
    end

endmodule

// File: tb/tb_oq_central_switch.sv
module tb_oq_central_switch;
    localparam int CLK_PERIOD = 10;
    localparam int NP   = 4;
    localparam int CW   = 16;
    localparam int DP   = 4;
    localparam int CNTW = 16;
    localparam int DW   = 2;
    localparam int OW   = 3;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NP-1:0]       in_vld  = '0;
    logic [NP*CW-1:0]    in_cell = '0;
    logic [NP*DW-1:0]    in_dst  = '0;
    logic [NP-1:0]       out_vld;
    logic [NP*CW-1:0]    out_cell;
    logic [NP*OW-1:0]    out_occ;
    logic [NP*CNTW-1:0]  out_drops;

    int checks = 0;
    int errors = 0;

    logic [CW-1:0] exp_q [NP][$];
    int            exp_drop [NP];
    logic [31:0]   rng = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    oq_central_switch #(
        .NPORT(NP), .CELL_W(CW), .DEPTH(DP), .CNT_W(CNTW)
    ) dut (
        .clk(clk), .rst(rst),
        .in_vld(in_vld), .in_cell(in_cell), .in_dst(in_dst),
        .out_vld(out_vld), .out_cell(out_cell),
        .out_occ(out_occ), .out_drops(out_drops)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        for (int j = 0; j < NP; j++) begin
            check(tag, $sformatf("out_vld[%0d]", j), int'(out_vld[j]), int'(exp_q[j].size() != 0));
            check(tag, $sformatf("occ[%0d]", j), int'(out_occ[j*OW +: OW]), exp_q[j].size());
            check(tag, $sformatf("drops[%0d]", j), int'(out_drops[j*CNTW +: CNTW]), exp_drop[j]);
            if (exp_q[j].size() != 0)
                check(tag, $sformatf("cell[%0d]", j), int'(out_cell[j*CW +: CW]), int'(exp_q[j][0]));
        end
    endtask

    // one slot: drive after a falling edge, update model, check after next falling edge
    task automatic step(input string tag, input logic [NP-1:0] v,
                        input logic [NP*CW-1:0] c, input logic [NP*DW-1:0] d);
        in_vld = v; in_cell = c; in_dst = d;
        for (int j = 0; j < NP; j++) begin
            if (exp_q[j].size() != 0) void'(exp_q[j].pop_front());
            for (int i = 0; i < NP; i++) begin
                if (v[i] && int'(d[i*DW +: DW]) == j) begin
                    if (exp_q[j].size() < DP) exp_q[j].push_back(c[i*CW +: CW]);
                    else exp_drop[j] = (exp_drop[j] + 1) % (1 << CNTW);
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        in_vld = '0;
        compare_all(tag);
    endtask

    function automatic logic [NP*DW-1:0] dsts(input int d0, input int d1, input int d2, input int d3);
        return {DW'(d3), DW'(d2), DW'(d1), DW'(d0)};
    endfunction

    function automatic logic [NP*CW-1:0] mk_cells(input int base);
        return {CW'(base + 3), CW'(base + 2), CW'(base + 1), CW'(base)};
    endfunction

    task automatic idle(input string tag, input int n);
        for (int k = 0; k < n; k++) step(tag, '0, '0, '0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int j = 0; j < NP; j++) begin
            exp_q[j].delete();
            exp_drop[j] = 0;
        end
        compare_all("R8");
    endtask

    task automatic t_route();
        // R1: permutation, input i goes to output (i+1)%NP
        step("R1", 4'b1111, mk_cells(16'h100), dsts(1, 2, 3, 0));
        // R3: each cell must be visible the slot after it was presented
        step("R3", '0, '0, '0);
        // R1: valid low with destinations set must change nothing
        step("R1", 4'b0000, mk_cells(16'h900), dsts(2, 2, 2, 2));
        check("R1", "occ[2] idle", int'(out_occ[2*OW +: OW]), 0);
    endtask

    task automatic t_all_to_one();
        // R2: four writes into one empty queue in a single slot
        step("R2", 4'b1111, mk_cells(16'h200), dsts(2, 2, 2, 2));
        check("R2", "occ[2] after burst", int'(out_occ[2*OW +: OW]), 4);
        // R3: drained in ascending input order
        idle("R3", 5);
    endtask

    task automatic t_overflow();
        // R4 / R5: partial admission keeps lower inputs, drops counted
        step("R4", 4'b0011, mk_cells(16'h300), dsts(0, 0, 1, 1));
        step("R4", 4'b1111, mk_cells(16'h310), dsts(0, 0, 0, 0));
        step("R5", 4'b1111, mk_cells(16'h320), dsts(0, 0, 0, 0));
        step("R5", 4'b1010, mk_cells(16'h330), dsts(0, 0, 0, 0));
        idle("R5", 5);
    endtask

    task automatic t_same_slot();
        // R6: a full, draining queue still takes one cell per slot
        step("R6", 4'b1111, mk_cells(16'h400), dsts(1, 1, 1, 1));
        step("R6", 4'b1111, mk_cells(16'h410), dsts(1, 1, 1, 1));
        check("R6", "occ[1] stays full", int'(out_occ[1*OW +: OW]), 4);
        step("R6", 4'b1000, mk_cells(16'h420), dsts(1, 1, 1, 1));
        idle("R6", 5);
    endtask

    task automatic t_random();
        // R7: heavy pseudo-random load against the reference queues
        for (int k = 0; k < 400; k++) begin
            logic [NP-1:0]    v;
            logic [NP*DW-1:0] d;
            logic [NP*CW-1:0] c;
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            v = rng[NP-1:0];
            d = rng[8 +: NP*DW];
            c = {rng[15:0], rng[31:16], rng[23:8], 16'(k)};
            step("R7", v, c, d);
        end
        idle("R7", 6);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_route();
        t_all_to_one();
        t_overflow();
        t_same_slot();
        t_random();
        t_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule